// File: doc/BRIEF.md
# Parallel Clause Propagation Array

This block holds a set of CNF clauses in a grid of clause rows and variable columns, and performs Boolean constraint propagation on all of them at once. Every cell keeps a two-bit literal code for one variable in one row. Each variable column has a three-bit status net made of a high-value line, a low-value line and an implied line. A decision engine outside the block drives decisions onto these nets. On every clock the array ORs its own implication and conflict drives into the nets. The nets only gain bits until the next refresh, so the array reaches a fixed point after a few cycles and then raises a settled flag.

A physical row is cut into segments of a fixed number of columns. A programmable end bit per segment decides whether the clause closes at that segment boundary or carries on into the next segment, so one row can hold several short clauses or one long one. Each clause counts its free literals with a two-bit saturating counter chained along the row. A clause with exactly one free literal forces that literal. A clause with no free literal re-drives every literal it holds. Because of this re-drive, a conflict spreads back through the clauses that caused it, and every variable involved ends up marked. Rows are loaded one at a time through a write port.

Top module: `clause_prop_engine`

## Requirements
- R1: A row write stores, for variable i, bit 2i+1 as the positive-literal flag and bit 2i as the negative-literal flag. 00 means absent, 10 positive, 01 negative, and 11 is never written. The new row contents take part in propagation from the next cycle.
- R2: Column status is read as {high, low, implied}. 000 is free, 100/010 is a decision of 1/0, 101/011 is an implication of 1/0, 111 is a conflict, 110 marks a member of the learned clause, and 001 never appears.
- R3: A refresh clears every column net to 000 and drops the settled flag at the next edge. Refresh takes priority over the external drives.
- R4: Outside refresh, each column net becomes its old value ORed with the external drive and the array drive, so no bit is lost until the next refresh.
- R5: A literal is satisfied only when its column is exactly 10x for a positive literal or exactly 01x for a negative one. A clause with a satisfied literal drives nothing.
- R6: The free-literal count saturates at two. A clause with two or more free literals drives nothing, whatever their number (five included).
- R7: An unsatisfied clause with exactly one free literal drives that literal's polarity onto its column together with the implied line (101 or 011).
- R8: An unsatisfied clause with at least one literal and no free literal ORs the polarity of every one of its literals onto the high/low lines, leaving the implied line alone. A unit clause whose literal set touches a column showing both value lines does the same.
- R9: Two clauses that force opposite values on one variable give that column 111. The back-trace then turns the decisions that caused it into 110.
- R10: End bit s closes a clause after segment s, and the last segment always closes one. Segments that are not closed join the following segment into one clause. A clause with no literal is inert.
- R11: The settled flag is high exactly when the nets did not change at the previous edge. Both a refresh and a row write clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; empties all rows and nets |
| refresh | input | 1 | Clears the column nets for a new propagation round |
| wrEn | input | 1 | Row write strobe |
| wrRow | input | ROW_AW | Row index to write |
| wrLits | input | 2*NUM_VARS | Literal codes, two bits per variable |
| wrTerm | input | NUM_SEGS | Clause-end bit for each segment of the row |
| extLit | input | NUM_VARS | External drive onto the high-value lines |
| extLitBar | input | NUM_VARS | External drive onto the low-value lines |
| extImp | input | NUM_VARS | External drive onto the implied lines |
| netLit | output | NUM_VARS | High-value line of each column |
| netLitBar | output | NUM_VARS | Low-value line of each column |
| netImp | output | NUM_VARS | Implied line of each column |
| settled | output | 1 | Nets did not change at the last edge |

## Verification
The assertions take the inputs as well formed. No row write carries the 11 literal code, and the external drive never raises the implied line of a column without also raising one of its value lines. Otherwise the status 001 could appear through the inputs rather than through the array. The bench keeps to this by driving only decisions (100 or 010) and clean refreshes. Every row image it writes is built from positive and negative masks that never overlap. The sweep covers every free, 0 and 1 choice for five decision variables on a fixed instance. That instance contains packed clauses, clauses that span segments, a five-literal clause, an empty row and a pair of contradicting clauses.

// File: rtl/clause_pkg.sv
package clause_pkg;

  typedef logic [1:0] freeCnt_t;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic clearNets;
    logic accumulate;
    logic loadRow;
  } strobe_t;

  // Saturating add of one free literal: the value 2 stands for "two or more"
  function automatic freeCnt_t freeInc(input freeCnt_t cnt, input logic isFree);
    if (cnt == 2'd2) return 2'd2;
    return cnt + {1'b0, isFree};
  endfunction

endpackage

// File: rtl/clause_row.sv
module clause_row
  import clause_pkg::*;
#(
  parameter int NUM_VARS = 12,
  parameter int SEG_W = 6,
  localparam int NUM_SEGS = NUM_VARS / SEG_W
) (
  input  logic [2*NUM_VARS-1:0] cellBits,
  input  logic [NUM_SEGS-1:0]   segEnd,
  input  logic [NUM_VARS-1:0]   netLit,
  input  logic [NUM_VARS-1:0]   netLitBar,
  output logic [NUM_VARS-1:0]   drvLit,
  output logic [NUM_VARS-1:0]   drvLitBar,
  output logic [NUM_VARS-1:0]   drvImp
);

  logic [NUM_VARS-1:0] posCell, negCell, partCell, freeCell, matchCell, hitCell;
  logic [NUM_SEGS-1:0] segUnit, segConf;

  // Per-cell decode
  for (genvar i = 0; i < NUM_VARS; i++) begin : g_cell
    assign posCell[i]   = cellBits[2*i+1];
    assign negCell[i]   = cellBits[2*i];
    assign partCell[i]  = posCell[i] | negCell[i];
    assign freeCell[i]  = partCell[i] & ~netLit[i] & ~netLitBar[i];
    assign matchCell[i] = (posCell[i] & netLit[i] & ~netLitBar[i]) |
                          (negCell[i] & netLitBar[i] & ~netLit[i]);
    assign hitCell[i]   = partCell[i] & netLit[i] & netLitBar[i];
  end

  // Chain along the row, closing a clause where a segment ends
  always_comb begin
    freeCnt_t cnt;
    logic sat, prt, hitAcc, curU, curC;
    logic [NUM_SEGS-1:0] clUnit, clConf;
    cnt = '0;
    sat = 1'b0;
    prt = 1'b0;
    hitAcc = 1'b0;
    clUnit = '0;
    clConf = '0;
    for (int s = 0; s < NUM_SEGS; s++) begin
      for (int c = 0; c < SEG_W; c++) begin
        cnt    = freeInc(cnt, freeCell[s*SEG_W+c]);
        sat    = sat | matchCell[s*SEG_W+c];
        prt    = prt | partCell[s*SEG_W+c];
        hitAcc = hitAcc | hitCell[s*SEG_W+c];
      end
      if (segEnd[s] || s == NUM_SEGS-1) begin
        clUnit[s] = prt & ~sat & (cnt == 2'd1);
        clConf[s] = prt & ~sat & ((cnt == 2'd0) | ((cnt == 2'd1) & hitAcc));
        cnt = '0;
        sat = 1'b0;
        prt = 1'b0;
        hitAcc = 1'b0;
      end
    end
    // Broadcast each clause result back over its own segments
    curU = 1'b0;
    curC = 1'b0;
    for (int s = NUM_SEGS-1; s >= 0; s--) begin
      if (segEnd[s] || s == NUM_SEGS-1) begin
        curU = clUnit[s];
        curC = clConf[s];
      end
      segUnit[s] = curU;
      segConf[s] = curC;
    end
  end

  for (genvar i = 0; i < NUM_VARS; i++) begin : g_drive
    localparam int SEG = i / SEG_W;
    assign drvLit[i]    = posCell[i] & (segConf[SEG] | (segUnit[SEG] & freeCell[i]));
    assign drvLitBar[i] = negCell[i] & (segConf[SEG] | (segUnit[SEG] & freeCell[i]));
    assign drvImp[i]    = segUnit[SEG] & freeCell[i];
  end

endmodule

// File: rtl/clause_ctrl.sv
module clause_ctrl
  import clause_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refresh,
  input  logic    wrEn,
  input  logic    netsChanged,
  output strobe_t strobes,
  output logic    settled
);

  always_comb begin
    strobes.clearNets  = refresh;
    strobes.accumulate = ~refresh;
    strobes.loadRow    = wrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settled <= 1'b0;
    end else if (refresh || wrEn) begin
      settled <= 1'b0;
    end else begin
      settled <= ~netsChanged;
    end
  end

endmodule

// File: rtl/clause_dp.sv
module clause_dp
  import clause_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_VARS = 12,
  parameter int SEG_W = 6,
  localparam int NUM_SEGS = NUM_VARS / SEG_W,
  localparam int ROW_AW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobes,
  input  logic [ROW_AW-1:0]     wrRow,
  input  logic [2*NUM_VARS-1:0] wrLits,
  input  logic [NUM_SEGS-1:0]   wrTerm,
  input  logic [NUM_VARS-1:0]   extLit,
  input  logic [NUM_VARS-1:0]   extLitBar,
  input  logic [NUM_VARS-1:0]   extImp,
  output logic [NUM_VARS-1:0]   netLit,
  output logic [NUM_VARS-1:0]   netLitBar,
  output logic [NUM_VARS-1:0]   netImp,
  output logic                  netsChanged
);

  logic [2*NUM_VARS-1:0] rowCells [NUM_ROWS];
  logic [NUM_SEGS-1:0]   rowEnds  [NUM_ROWS];
  logic [NUM_VARS-1:0]   rowDrvLit [NUM_ROWS];
  logic [NUM_VARS-1:0]   rowDrvLitBar [NUM_ROWS];
  logic [NUM_VARS-1:0]   rowDrvImp [NUM_ROWS];
  logic [NUM_VARS-1:0]   orLit, orLitBar, orImp;
  logic [NUM_VARS-1:0]   nextLit, nextLitBar, nextImp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        rowCells[r] <= '0;
        rowEnds[r]  <= '0;
      end
    end else if (strobes.loadRow) begin
      rowCells[wrRow] <= wrLits;
      rowEnds[wrRow]  <= wrTerm;
    end
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    clause_row #(
      .NUM_VARS(NUM_VARS),
      .SEG_W(SEG_W)
    ) u_row (
      .cellBits (rowCells[r]),
      .segEnd   (rowEnds[r]),
      .netLit   (netLit),
      .netLitBar(netLitBar),
      .drvLit   (rowDrvLit[r]),
      .drvLitBar(rowDrvLitBar[r]),
      .drvImp   (rowDrvImp[r])
    );
  end

  // Wired-OR of all rows onto the column nets
  always_comb begin
    orLit = '0;
    orLitBar = '0;
    orImp = '0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      orLit    = orLit | rowDrvLit[r];
      orLitBar = orLitBar | rowDrvLitBar[r];
      orImp    = orImp | rowDrvImp[r];
    end
  end

  assign nextLit     = netLit | extLit | orLit;
  assign nextLitBar  = netLitBar | extLitBar | orLitBar;
  assign nextImp     = netImp | extImp | orImp;
  assign netsChanged = {nextLit, nextLitBar, nextImp} != {netLit, netLitBar, netImp};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      netLit    <= '0;
      netLitBar <= '0;
      netImp    <= '0;
    end else if (strobes.clearNets) begin
      netLit    <= '0;
      netLitBar <= '0;
      netImp    <= '0;
    end else if (strobes.accumulate) begin
      netLit    <= nextLit;
      netLitBar <= nextLitBar;
      netImp    <= nextImp;
    end
  end

endmodule

// File: rtl/clause_prop_engine.sv
module clause_prop_engine
  import clause_pkg::*;
#(
  parameter int NUM_ROWS = 8,
  parameter int NUM_VARS = 12,
  parameter int SEG_W = 6,
  localparam int NUM_SEGS = NUM_VARS / SEG_W,
  localparam int ROW_AW = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refresh,
  input  logic                  wrEn,
  input  logic [ROW_AW-1:0]     wrRow,
  input  logic [2*NUM_VARS-1:0] wrLits,
  input  logic [NUM_SEGS-1:0]   wrTerm,
  input  logic [NUM_VARS-1:0]   extLit,
  input  logic [NUM_VARS-1:0]   extLitBar,
  input  logic [NUM_VARS-1:0]   extImp,
  output logic [NUM_VARS-1:0]   netLit,
  output logic [NUM_VARS-1:0]   netLitBar,
  output logic [NUM_VARS-1:0]   netImp,
  output logic                  settled
);

  strobe_t strobes;
  logic    netsChanged;

  clause_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refresh    (refresh),
    .wrEn       (wrEn),
    .netsChanged(netsChanged),
    .strobes    (strobes),
    .settled    (settled)
  );

  clause_dp #(
    .NUM_ROWS(NUM_ROWS),
    .NUM_VARS(NUM_VARS),
    .SEG_W(SEG_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrRow      (wrRow),
    .wrLits     (wrLits),
    .wrTerm     (wrTerm),
    .extLit     (extLit),
    .extLitBar  (extLitBar),
    .extImp     (extImp),
    .netLit     (netLit),
    .netLitBar  (netLitBar),
    .netImp     (netImp),
    .netsChanged(netsChanged)
  );

endmodule

// File: rtl/clause_prop_chk.sv
module clause_prop_chk #(
  parameter int NUM_VARS = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  refresh,
  input logic                  wrEn,
  input logic [2*NUM_VARS-1:0] wrLits,
  input logic [NUM_VARS-1:0]   netLit,
  input logic [NUM_VARS-1:0]   netLitBar,
  input logic [NUM_VARS-1:0]   netImp,
  input logic                  settled
);

  logic badPair;
  always_comb begin
    badPair = 1'b0;
    for (int i = 0; i < NUM_VARS; i++) badPair = badPair | (wrLits[2*i+1] & wrLits[2*i]);
  end

  // R1
  legal_cell_chk: assert property (@(posedge clk) disable iff (!rstN) wrEn |-> !badPair);

  // R2
  no_bare_imp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (netImp & ~(netLit | netLitBar)) == '0);

  // R3
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    refresh |=> (netLit == '0 && netLitBar == '0 && netImp == '0 && !settled));

  // R4
  monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    !refresh |=> (((netLit & $past(netLit)) == $past(netLit)) &&
                  ((netLitBar & $past(netLitBar)) == $past(netLitBar)) &&
                  ((netImp & $past(netImp)) == $past(netImp))));

  // R11
  settled_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    settled |-> ($stable(netLit) && $stable(netLitBar) && $stable(netImp)));

  // R11
  write_unsettle_chk: assert property (@(posedge clk) disable iff (!rstN) wrEn |=> !settled);

endmodule

bind clause_prop_engine clause_prop_chk #(.NUM_VARS(NUM_VARS)) u_chk (.*);

// File: tb/clause_prop_engine_tb.sv
`timescale 1ns/1ps
module clause_prop_engine_tb;

  localparam int NR = 8;
  localparam int NV = 12;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refresh = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrRow = '0;
  logic [2*NV-1:0] wrLits = '0;
  logic [1:0] wrTerm = '0;
  logic [NV-1:0] extLit = '0, extLitBar = '0, extImp = '0;
  logic [NV-1:0] netLit, netLitBar, netImp;
  logic settled;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [NV-1:0] rowPos [NR];
  logic [NV-1:0] rowNeg [NR];
  logic [1:0]    rowTerm [NR];
  logic [NV-1:0] clPos [16];
  logic [NV-1:0] clNeg [16];
  int nCl;

  clause_prop_engine #(.NUM_ROWS(NR), .NUM_VARS(NV), .SEG_W(SW)) u_dut (
    .clk(clk), .rstN(rstN), .refresh(refresh), .wrEn(wrEn), .wrRow(wrRow),
    .wrLits(wrLits), .wrTerm(wrTerm), .extLit(extLit), .extLitBar(extLitBar),
    .extImp(extImp), .netLit(netLit), .netLitBar(netLitBar), .netImp(netImp),
    .settled(settled)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected completion", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [NV-1:0] l, b, i,
                       input logic [NV-1:0] el, eb, ei);
    checks++;
    if (l !== el || b !== eb || i !== ei) begin
      errors++;
      $display("FAIL %s: actual lit=%h bar=%h imp=%h expected lit=%h bar=%h imp=%h",
               req, l, b, i, el, eb, ei);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [2*NV-1:0] packRow(input logic [NV-1:0] p, input logic [NV-1:0] n);
    logic [2*NV-1:0] v;
    for (int i = 0; i < NV; i++) begin
      v[2*i+1] = p[i];
      v[2*i]   = n[i];
    end
    return v;
  endfunction

  task automatic writeRow(input int r);
    @(negedge clk);
    wrEn = 1'b1;
    wrRow = 3'(r);
    wrLits = packRow(rowPos[r], rowNeg[r]);
    wrTerm = rowTerm[r];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Split rows into clauses at the end bits (last segment always closes)
  task automatic buildClauses();
    logic [NV-1:0] aP, aN, m;
    nCl = 0;
    for (int r = 0; r < NR; r++) begin
      aP = '0;
      aN = '0;
      for (int s = 0; s < NV/SW; s++) begin
        m = ((NV'(1) << SW) - 1) << (s*SW);
        aP |= rowPos[r] & m;
        aN |= rowNeg[r] & m;
        if (rowTerm[r][s] || s == NV/SW-1) begin
          clPos[nCl] = aP;
          clNeg[nCl] = aN;
          nCl++;
          aP = '0;
          aN = '0;
        end
      end
    end
  endtask

  // Parallel fixed-point propagation built from the requirements
  task automatic runModel(input logic [NV-1:0] eL, eB, eI,
                          output logic [NV-1:0] mL, mB, mI);
    logic [NV-1:0] l, b, im, nl, nb, ni, fm, vars;
    logic sat;
    int fc;
    l = eL; b = eB; im = eI;
    for (int it = 0; it < 40; it++) begin
      nl = l | eL; nb = b | eB; ni = im | eI;
      for (int k = 0; k < nCl; k++) begin
        vars = clPos[k] | clNeg[k];
        sat = ((clPos[k] & l & ~b) | (clNeg[k] & b & ~l)) != '0;
        fm = vars & ~l & ~b;
        fc = $countones(fm);
        if (vars != '0 && !sat) begin
          if (fc == 1) begin
            nl |= clPos[k] & fm;
            nb |= clNeg[k] & fm;
            ni |= fm;
          end
          if (fc == 0 || (fc == 1 && (vars & l & b) != '0)) begin
            nl |= clPos[k];
            nb |= clNeg[k];
          end
        end
      end
      l = nl; b = nb; im = ni;
    end
    mL = l; mB = b; mI = im;
  endtask

  // Refresh with drives applied, then wait for settled
  task automatic runCase(input logic [NV-1:0] eL, eB, eI);
    int n;
    @(negedge clk);
    refresh = 1'b1;
    extLit = eL; extLitBar = eB; extImp = eI;
    @(negedge clk);
    refresh = 1'b0;
    n = 0;
    while (!settled && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (!settled) begin
      checks++;
      errors++;
      $display("FAIL R11: actual settled=0 after %0d cycles expected settled=1", n);
    end
  endtask

  initial begin
    logic [NV-1:0] mL, mB, mI, sL, sB, sI, eL, eB;
    string tag;
    int d;

    // Instance: packed, spanning, five-literal, empty and contradicting clauses
    for (int r = 0; r < NR; r++) begin rowPos[r] = '0; rowNeg[r] = '0; rowTerm[r] = 2'b11; end
    rowNeg[0] = 12'h041; rowPos[0] = 12'h0A0; rowTerm[0] = 2'b11; // (~x0|x5) and (~x6|x7)
    rowNeg[1] = 12'h020; rowPos[1] = 12'h040; rowTerm[1] = 2'b10; // (~x5|x6) spanning
    rowNeg[2] = 12'h086; rowPos[2] = 12'h208; rowTerm[2] = 2'b11; // (~x1|~x2|x3) and (~x7|x9)
    rowNeg[3] = 12'h288;                      rowTerm[3] = 2'b00; // (~x3|~x7|~x9) spanning
    rowNeg[4] = 12'h010; rowPos[4] = 12'h400; rowTerm[4] = 2'b10; // (~x4|x10)
    rowNeg[5] = 12'h410;                      rowTerm[5] = 2'b00; // (~x4|~x10)
    rowPos[6] = 12'hF40;                      rowTerm[6] = 2'b01; // empty seg0, five literals seg1
    buildClauses();

    repeat (4) @(negedge clk);
    // R3: reset state
    check("R3 reset", netLit, netLitBar, netImp, '0, '0, '0);
    checkBit("R11 reset settled", settled, 1'b0);
    rstN = 1'b1;

    for (int r = 0; r < NR; r++) writeRow(r);
    // R11: a write clears settled
    checkBit("R11 write clears settled", settled, 1'b0);

    // R6: all free, five-literal clause must not imply
    runCase('0, '0, '0);
    check("R6 all free", netLit, netLitBar, netImp, '0, '0, '0);

    // R7 and R10: x0=1 ripples through split and spanning clauses
    runCase(12'h001, '0, '0);
    check("R7 R10 chain", netLit, netLitBar, netImp, 12'h2E1, 12'h008, 12'h2E8);
    sL = netLit; sB = netLitBar; sI = netImp;
    @(negedge clk);
    // R11: remains settled and stable
    checkBit("R11 stays settled", settled, 1'b1);
    // R4: removing the drive without refresh loses nothing
    extLit = '0;
    repeat (3) @(negedge clk);
    check("R4 hold", netLit, netLitBar, netImp, sL, sB, sI);

    // R3: refresh clears the nets even with drive present
    @(negedge clk);
    refresh = 1'b1; extLit = 12'h001;
    @(negedge clk);
    refresh = 1'b0; extLit = '0;
    check("R3 refresh", netLit, netLitBar, netImp, '0, '0, '0);

    // R8: x1=1, x2=1, x3=0 falsify a clause, all become 110
    runCase(12'h006, 12'h008, '0);
    check("R8 conflict", netLit, netLitBar, netImp, 12'h00E, 12'h00E, '0);

    // R9: x4=1 gives opposite implications on x10
    runCase(12'h010, '0, '0);
    check("R9 opposite", netLit, netLitBar, netImp, 12'h410, 12'h410, 12'h400);

    // Sweep every free/0/1 choice over x0..x4 (R5, R7, R9)
    for (int p = 0; p < 243; p++) begin
      eL = '0; eB = '0;
      d = p;
      for (int v = 0; v < 5; v++) begin
        if (d % 3 == 1) eB[v] = 1'b1;
        if (d % 3 == 2) eL[v] = 1'b1;
        d = d / 3;
      end
      runCase(eL, eB, '0);
      runModel(eL, eB, '0, mL, mB, mI);
      if ((mL & mB & mI) != '0) tag = "R9 sweep";
      else if (mI != '0) tag = "R7 sweep";
      else tag = "R5 sweep";
      check(tag, netLit, netLitBar, netImp, mL, mB, mI);
    end

    // R1: rewrite row 4 empty, only (~x4|~x10) remains
    rowPos[4] = '0; rowNeg[4] = '0;
    writeRow(4);
    runCase(12'h010, '0, '0);
    check("R1 rewrite", netLit, netLitBar, netImp, 12'h010, 12'h400, 12'h400);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule